// File: doc/BRIEF.md
# Raw and Masked Interrupt Status Registers

This block collects one-cycle event pulses from a memory controller and turns them into a single active-high interrupt for the CPU. Each event source owns one bit position in four word-wide registers. Source bit 0 is the asynchronous-timeout event.

- The raw status register records every event, whatever the enable state.
- The masked status register records only the events that arrive while their source is enabled.
- The per-source enable bit can only be reached through two write-one strobe registers: one sets it and one clears it. Both registers read back the same enable vector.

Software services an interrupt by writing 1 to the raw status bit. That clears the raw bit and the matching masked bit at the same time. The interrupt output stays high for as long as any enabled masked bit is set.

The register port is a simple single-cycle bus with a byte-lane enable. Only full, aligned 32-bit writes have any effect. Reads are combinational from the current register state.

Register map (byte offsets): 0x00 raw status, 0x04 masked status, 0x08 enable-set, 0x0C enable-clear. All other offsets read 0 and ignore writes.

Top module: `irq_status_regs`

## Requirements
- R1: After reset, all four registers read 0 (all enables are 0) and `irq_out` is 0.
- R2: An `evt_pulse[i]` high for one cycle sets raw bit i (offset 0x00) on the next clock edge, whether or not source i is enabled. Bit 0 is the asynchronous-timeout source. A raw bit never sets without its event.
- R3: A write to offset 0x00 clears every raw bit written as 1, and clears the matching masked bits. Bits written as 0 are left unchanged.
- R4: Masked bit i (offset 0x04) sets only when `evt_pulse[i]` arrives while source i is already enabled. `irq_out` is the OR of the masked bits and stays 1 until software clears them.
- R5: Writing 1 to bit i at offset 0x08 enables source i. The enable vector reads back identically at both 0x08 and 0x0C.
- R6: Writing 1 to bit i at offset 0x0C disables source i and clears masked bit i, even if an event arrives in the same cycle. A disabled source's masked bit reads 0, and re-enabling it does not bring back an old masked state.
- R7: When an event and a write-one-to-clear of its raw bit fall in the same cycle, the event wins, and both the raw and the masked bit (if enabled) end up set.
- R8: Bit positions at or above NUM_SRC read 0 and ignore writes. Offsets outside 0x00 to 0x0C read 0, and writes to them change nothing.
- R9: Only aligned full-word writes (`bus_be` = 4'hF and `bus_addr[1:0]` = 0) take effect. Any other write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses; bit 0 is the asynchronous timeout |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| irq_out | output | 1 | Active-high interrupt to the CPU |

## Verification
The function that can collide with event capture is software's write-one-to-clear of the same raw bit. The bench provokes this by driving an event pulse in the very cycle that a clear of that bit is written. It then reads both status registers and the interrupt line afterwards and expects the bit still set, as R7 says the event wins. A second collision is also driven: an event arriving in the same cycle as a write to the enable-clear register. There the masked bit must read 0, and the interrupt must stay low.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        REG_RAW    = 2'd0,
        REG_MASKED = 2'd1,
        REG_EN_SET = 2'd2,
        REG_EN_CLR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_hit_t;

    // per-source write commands produced by the bus decoder
    typedef struct packed {
        logic raw_clr;
        logic en_set;
        logic en_clr;
    } bit_cmd_t;

    // per-source stored state
    typedef struct packed {
        logic raw;
        logic en;
        logic msk;
    } bit_state_t;

    // address is zero-extended to a full word before decoding
    function automatic reg_hit_t decode_addr(input logic [WORD_W-1:0] addr);
        reg_hit_t r;
        r.hit = (addr[1:0] == 2'b00) && (addr[WORD_W-1:4] == '0);
        r.sel = reg_sel_e'(addr[3:2]);
        return r;
    endfunction

    function automatic logic full_word(input logic [BE_W-1:0] be);
        return &be;
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  bit_cmd_t   cmd,
    output bit_state_t state
);

    bit_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            // an event takes precedence over a clear of the raw bit
            st_q.raw <= evt | (st_q.raw & ~cmd.raw_clr);
            st_q.en  <= cmd.en_set | (st_q.en & ~cmd.en_clr);
            if (cmd.en_clr)
                st_q.msk <= 1'b0;
            else
                st_q.msk <= (evt & st_q.en) | (st_q.msk & ~cmd.raw_clr);
        end
    end

    assign state = st_q;

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_regs_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 5
) (
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BE_W-1:0]         bus_be,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  bit_state_t [NUM_SRC-1:0] state,
    output bit_cmd_t   [NUM_SRC-1:0] cmd,
    output logic [WORD_W-1:0]       bus_rdata
);

    localparam int PAD_W = WORD_W - ADDR_W;

    reg_hit_t            hit;
    logic                wr_ok;
    logic [NUM_SRC-1:0]  raw_v, en_v, msk_v;

    assign hit   = decode_addr({{PAD_W{1'b0}}, bus_addr});
    assign wr_ok = bus_sel && bus_wr && hit.hit && full_word(bus_be);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bits
        assign cmd[i].raw_clr = wr_ok && (hit.sel == REG_RAW)    && bus_wdata[i];
        assign cmd[i].en_set  = wr_ok && (hit.sel == REG_EN_SET) && bus_wdata[i];
        assign cmd[i].en_clr  = wr_ok && (hit.sel == REG_EN_CLR) && bus_wdata[i];
        assign raw_v[i] = state[i].raw;
        assign en_v[i]  = state[i].en;
        assign msk_v[i] = state[i].msk & state[i].en;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && hit.hit) begin
            unique case (hit.sel)
                REG_RAW:    bus_rdata[NUM_SRC-1:0] = raw_v;
                REG_MASKED: bus_rdata[NUM_SRC-1:0] = msk_v;
                REG_EN_SET,
                REG_EN_CLR: bus_rdata[NUM_SRC-1:0] = en_v;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_regs_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);

    bit_cmd_t   [NUM_SRC-1:0] cmd;
    bit_state_t [NUM_SRC-1:0] state;
    logic [NUM_SRC-1:0] raw_vec, en_vec, msk_vec;

    irq_bus_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .state     (state),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt_pulse[i]),
            .cmd   (cmd[i]),
            .state (state[i])
        );
        assign raw_vec[i] = state[i].raw;
        assign en_vec[i]  = state[i].en;
        assign msk_vec[i] = state[i].msk;
    end

    assign irq_out = |(msk_vec & en_vec);

endmodule

// File: rtl/irq_status_regs_chk.sv
module irq_status_regs_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] msk,
    input logic               irq
);

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (raw == '0 && en == '0 && !irq)); // R1

    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((raw & $past(evt)) == $past(evt))); // R2

    AST_RAW_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~$past(raw) & ~$past(evt)) == '0)); // R2

    AST_MSK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        ((msk & ~$past(msk) & ~($past(evt) & $past(en))) == '0)); // R4

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw != '0)); // R4

    AST_MSK_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
        ((msk & ~en) == '0)); // R6

endmodule

bind irq_status_regs irq_status_regs_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk (clk),
    .rst (rst),
    .evt (evt_pulse),
    .raw (raw_vec),
    .en  (en_vec),
    .msk (msk_vec),
    .irq (irq_out)
);

// File: tb/irq_status_regs_bench.sv
module irq_status_regs_bench;

    localparam int NUM_SRC = 4;
    localparam int ADDR_W  = 5;
    localparam logic [ADDR_W-1:0] A_RAW = 5'h00, A_MSK = 5'h04, A_SET = 5'h08,
                                  A_CLR = 5'h0C, A_BAD = 5'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_SRC-1:0] evt_pulse = '0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_out;

    always #4 clk = ~clk;

    irq_status_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irq_status_regs (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.data || irq_out !== e.irq) begin
                errors++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, irq_out, e.data, e.irq);
            end
        end
    end

    task automatic idle();
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0; evt_pulse = '0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic i, input string tag);
        exp_t e;
        e.data = d; e.irq = i; e.tag = tag;
        @(posedge clk); #2;
        evt_pulse = '0;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(e);
        idle();
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [NUM_SRC-1:0] ev);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        evt_pulse = ev;
        idle();
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] ev);
        @(posedge clk); #2;
        evt_pulse = ev;
        idle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        rd(A_RAW, 32'h0, 0, "R1 raw");
        rd(A_MSK, 32'h0, 0, "R1 masked");
        rd(A_SET, 32'h0, 0, "R1 enset");
        rd(A_CLR, 32'h0, 0, "R1 enclr");
        // R2 timeout event while disabled
        pulse(4'b0001);
        rd(A_RAW, 32'h1, 0, "R2 raw on disabled event");
        rd(A_MSK, 32'h0, 0, "R4 masked stays 0 when disabled");
        // R3 zero write no effect, one write clears
        wr(A_RAW, 32'h0, 4'hF, '0);
        rd(A_RAW, 32'h1, 0, "R3 zero write ignored");
        wr(A_RAW, 32'h1, 4'hF, '0);
        rd(A_RAW, 32'h0, 0, "R3 w1c clears raw");
        // R5 enable all, unused bits dropped (R8)
        wr(A_SET, 32'hFFFF_FFFF, 4'hF, '0);
        rd(A_SET, 32'hF, 0, "R5 R8 enset readback");
        rd(A_CLR, 32'hF, 0, "R5 enclr readback");
        // R4 enabled event raises interrupt and holds
        pulse(4'b0001);
        rd(A_MSK, 32'h1, 1, "R4 masked set with irq");
        rd(A_RAW, 32'h1, 1, "R4 irq held");
        // R3 clearing raw clears masked too
        wr(A_RAW, 32'h1, 4'hF, '0);
        rd(A_MSK, 32'h0, 0, "R3 masked cleared by raw w1c");
        rd(A_RAW, 32'h0, 0, "R3 raw cleared");
        // R7 event collides with w1c of the same bit
        pulse(4'b0100);
        wr(A_RAW, 32'h4, 4'hF, 4'b0100);
        rd(A_RAW, 32'h4, 1, "R7 raw kept by event");
        rd(A_MSK, 32'h4, 1, "R7 masked kept by event");
        // R6 disable clears masked and drops irq
        wr(A_CLR, 32'h4, 4'hF, '0);
        rd(A_MSK, 32'h0, 0, "R6 masked reads 0 disabled");
        rd(A_SET, 32'hB, 0, "R6 enable vector");
        rd(A_RAW, 32'h4, 0, "R6 raw untouched");
        // R9 partial and misaligned writes ignored
        wr(A_CLR, 32'hF, 4'h3, '0);
        wr(A_CLR + 5'd1, 32'hF, 4'hF, '0);
        rd(A_SET, 32'hB, 0, "R9 non-word writes ignored");
        // R8 unmapped offset
        wr(A_BAD, 32'hF, 4'hF, '0);
        rd(A_BAD, 32'h0, 0, "R8 unmapped reads 0");
        rd(A_SET, 32'hB, 0, "R8 unmapped write no effect");
        // R6 re-enable does not restore masked
        wr(A_SET, 32'h4, 4'hF, '0);
        rd(A_MSK, 32'h0, 0, "R6 no stale masked");
        // R6 disable collides with event
        wr(A_CLR, 32'h2, 4'hF, 4'b0010);
        rd(A_MSK, 32'h0, 0, "R6 disable beats event");
        rd(A_RAW, 32'h6, 0, "R2 raw set during disable");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule